// File: doc/BRIEF.md
# Service-Acknowledge Context Switch Controller

This block lives in the CPU bus interface of a multi-channel serial controller. It serves three classes of service request: receive, transmit and modem. Each class has its own active-low acknowledge strobe. When the CPU pulses one of these strobes, the block does two things in one bus transaction. It drives the vector of the requesting channel onto the read data bus. It also switches the channel-select register to that channel and enters the matching service mode. The register contents and mode that were in force before the switch go into a one-deep save slot.

The service routine ends with a write of any value to an end-of-service address. That write restores the saved channel and mode. Arbitration between channels happens outside the block. The pending flag and channel number for each class, the vector service-kind fields and the daisy-chain chip identifier all arrive as inputs. The strobes are asynchronous and are synchronized before use. Outside service context the CPU can read and write the channel-select register and read a status byte through a small register port.

Top module: `svc_ack_ctrl`

## Requirements
- R1: After reset the channel-select register is 0, the mode is normal (code 0), no service context is active, the ignored flag is clear and `rdata_oe` is low.
- R2: A falling acknowledge strobe is synchronized through two flops. Three rising clock edges after the strobe goes low, `rdata_oe` is high and `rdata` carries the vector. After only two edges, `rdata_oe` is still low. The vector is the chip ID in bits 7:3 and that class's service-kind code in bits 2:0.
- R3: An acknowledge with its class's request pending does four things. It loads the channel-select register from that class's channel: `chan_rx`, `chan_tx`, or bits 1:0 of `mdm_irq` for modem. It sets the mode to 1 (receive), 2 (transmit) or 3 (modem). It marks the service context active. It saves the prior channel and mode.
- R4: An acknowledge whose class has no pending request returns an all-zero vector. It leaves the channel, the mode and the active state unchanged.
- R5: An acknowledge that arrives while a service context is active is ignored. The vector is zero, and the channel and mode do not change. The ignored flag (status bit 7) is set.
- R6: A write of any data to address 2 while active restores the saved channel and mode. It also clears the active state and the ignored flag. The same write while idle has no effect.
- R7: A write to address 0 loads the channel-select register from `wdata[1:0]` when no service context is active. While a context is active, the write is ignored.
- R8: `rdata_oe` is high only while an acknowledge is live or `cs && rd` is asserted. It drops three clock edges after the strobe returns high.
- R9: If several strobes fall in the same cycle, receive wins over transmit and transmit wins over modem. Only the winner is serviced, and the ignored flag is set for the losers.
- R10: The register port reads as follows:
  - Address 0 returns the channel-select register, zero-extended.
  - Address 1 returns status: bit 7 is the ignored flag, bit 6 is active, bits 1:0 are the mode, and the other bits are 0.
  - Address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_rx_n | input | 1 | Receive acknowledge strobe, active low, asynchronous |
| ack_tx_n | input | 1 | Transmit acknowledge strobe, active low, asynchronous |
| ack_mdm_n | input | 1 | Modem acknowledge strobe, active low, asynchronous |
| req_rx | input | 1 | Receive request pending |
| req_tx | input | 1 | Transmit request pending |
| req_mdm | input | 1 | Modem request pending |
| chan_rx | input | 2 | Channel requesting receive service |
| chan_tx | input | 2 | Channel requesting transmit service |
| mdm_irq | input | 8 | Modem interrupt byte, channel in bits 1:0 |
| chip_id | input | 5 | Daisy-chain chip identifier |
| kind_rx | input | 3 | Receive service-kind code |
| kind_tx | input | 3 | Transmit service-kind code |
| kind_mdm | input | 3 | Modem service-kind code |
| cs | input | 1 | Register port select |
| rd | input | 1 | Register read |
| wr | input | 1 | Register write |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data / vector |
| rdata_oe | output | 1 | Read data bus drive enable |

## Verification
The bench measures how many edges the vector takes to appear, one edge before it is due and again on the edge it is due. A design with a wrong synchronizer depth or an extra register stage fails that check. A second acknowledge is sent while service is still open. A design that nests contexts or overwrites the save slot would lose the original channel at the end-of-service write, and the bench catches that. Two further cases probe the guard logic. One is an acknowledge with no pending request. The other is an end-of-service write while idle, which would clobber the channel register if the guard were missing. Simultaneous strobes expose a wrong priority order, because the channel and vector would then come from the wrong class.

// File: rtl/svc_pkg.sv
package svc_pkg;

  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_RX   = 2'd1,
    MODE_TX   = 2'd2,
    MODE_MDM  = 2'd3
  } svc_mode_e;

  localparam int N_CLASS = 3;
  localparam int IDX_RX  = 0;
  localparam int IDX_TX  = 1;
  localparam int IDX_MDM = 2;

  // Fixed priority: lowest index (receive) wins.
  function automatic logic [N_CLASS-1:0] pick_first(input logic [N_CLASS-1:0] f);
    logic [N_CLASS-1:0] r;
    r = '0;
    for (int i = N_CLASS - 1; i >= 0; i--) begin
      if (f[i]) r = N_CLASS'(1) << i;
    end
    return r;
  endfunction

  function automatic svc_mode_e mode_of(input logic [N_CLASS-1:0] onehot);
    svc_mode_e m;
    m = MODE_NORM;
    if (onehot[IDX_RX])       m = MODE_RX;
    else if (onehot[IDX_TX])  m = MODE_TX;
    else if (onehot[IDX_MDM]) m = MODE_MDM;
    return m;
  endfunction

endpackage

// File: rtl/svc_strobe_sync.sv
module svc_strobe_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strobe_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] low
);

  for (genvar g = 0; g < N; g++) begin : g_lane
    // sh[STAGES-1:0] synchronizer chain, sh[STAGES] previous synced level
    logic [STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], strobe_n[g]};
    end
    assign fall[g] = sh[STAGES] & ~sh[STAGES-1];
    assign low[g]  = ~sh[STAGES-1];
  end

endmodule

// File: rtl/svc_ctx_regs.sv
module svc_ctx_regs
  import svc_pkg::*;
#(
  parameter int CHAN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_valid,
  input  logic [CHAN_W-1:0] grant_chan,
  input  svc_mode_e         grant_mode,
  input  logic              eos_hit,
  input  logic              car_wr_hit,
  input  logic [CHAN_W-1:0] car_wdata,
  input  logic              ignore_evt,
  output logic [CHAN_W-1:0] car,
  output svc_mode_e         mode,
  output logic              active,
  output logic [CHAN_W-1:0] save_car,
  output svc_mode_e         save_mode,
  output logic              ignored_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car       <= '0;
      mode      <= MODE_NORM;
      active    <= 1'b0;
      save_car  <= '0;
      save_mode <= MODE_NORM;
    end else if (grant_valid) begin
      save_car  <= car;
      save_mode <= mode;
      car       <= grant_chan;
      mode      <= grant_mode;
      active    <= 1'b1;
    end else if (eos_hit) begin
      car    <= save_car;
      mode   <= save_mode;
      active <= 1'b0;
    end else if (car_wr_hit) begin
      car <= car_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ignored_flag <= 1'b0;
    else if (ignore_evt) ignored_flag <= 1'b1;
    else if (eos_hit)    ignored_flag <= 1'b0;
  end

endmodule

// File: rtl/svc_bus_port.sv
module svc_bus_port #(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 2
) (
  input  logic              live,
  input  logic [DATA_W-1:0] vec_q,
  input  logic              rd_sel,
  input  logic [1:0]        addr,
  input  logic [CHAN_W-1:0] car,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);

  always_comb begin
    rdata = '0;
    if (live) begin
      rdata = vec_q;
    end else if (rd_sel) begin
      case (addr)
        2'd0:    rdata = DATA_W'(car);
        2'd1:    rdata = status;
        default: rdata = '0;
      endcase
    end
  end

  assign rdata_oe = live | rd_sel;

endmodule

// File: rtl/svc_ack_ctrl.sv
module svc_ack_ctrl
  import svc_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ID_W        = 5,
  parameter int CHAN_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ack_rx_n,
  input  logic                   ack_tx_n,
  input  logic                   ack_mdm_n,
  input  logic                   req_rx,
  input  logic                   req_tx,
  input  logic                   req_mdm,
  input  logic [CHAN_W-1:0]      chan_rx,
  input  logic [CHAN_W-1:0]      chan_tx,
  input  logic [DATA_W-1:0]      mdm_irq,
  input  logic [ID_W-1:0]        chip_id,
  input  logic [DATA_W-ID_W-1:0] kind_rx,
  input  logic [DATA_W-ID_W-1:0] kind_tx,
  input  logic [DATA_W-ID_W-1:0] kind_mdm,
  input  logic                   cs,
  input  logic                   rd,
  input  logic                   wr,
  input  logic [1:0]             addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic                   rdata_oe
);

  localparam int KIND_W = DATA_W - ID_W;
  localparam logic [1:0] A_CAR = 2'd0;
  localparam logic [1:0] A_EOS = 2'd2;

  // Named internal events
  logic [N_CLASS-1:0] fall, strobe_low, winner, pend;
  logic               any_fall, grant_valid, ctx_switch, ignore_evt;
  logic               eos_hit, car_wr_hit, rd_sel;
  logic [CHAN_W-1:0]  grant_chan, car, save_car;
  svc_mode_e          grant_mode, mode, save_mode;
  logic               active, ignored_flag, live;
  logic [KIND_W-1:0]  win_kind;
  logic [DATA_W-1:0]  vec_next, vec_q, status;

  svc_strobe_sync #(.N(N_CLASS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n ({ack_mdm_n, ack_tx_n, ack_rx_n}),
    .fall     (fall),
    .low      (strobe_low)
  );

  assign pend        = {req_mdm, req_tx, req_rx};
  assign any_fall    = |fall;
  assign winner      = pick_first(fall);
  assign grant_valid = any_fall & ~active & (|(winner & pend));
  assign ctx_switch  = grant_valid;
  assign ignore_evt  = any_fall & (active | (|(fall & ~winner)));
  assign grant_mode  = mode_of(winner);

  always_comb begin
    grant_chan = '0;
    win_kind   = '0;
    if (winner[IDX_RX]) begin
      grant_chan = chan_rx;
      win_kind   = kind_rx;
    end else if (winner[IDX_TX]) begin
      grant_chan = chan_tx;
      win_kind   = kind_tx;
    end else if (winner[IDX_MDM]) begin
      grant_chan = mdm_irq[CHAN_W-1:0];
      win_kind   = kind_mdm;
    end
  end

  assign vec_next = grant_valid ? {chip_id, win_kind} : '0;

  assign rd_sel     = cs & rd;
  assign eos_hit    = cs & wr & (addr == A_EOS) & active;
  assign car_wr_hit = cs & wr & (addr == A_CAR) & ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live  <= 1'b0;
      vec_q <= '0;
    end else if (any_fall) begin
      live  <= 1'b1;
      vec_q <= vec_next;
    end else if (~|strobe_low) begin
      live  <= 1'b0;
    end
  end

  svc_ctx_regs #(.CHAN_W(CHAN_W)) u_ctx (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant_valid  (ctx_switch),
    .grant_chan   (grant_chan),
    .grant_mode   (grant_mode),
    .eos_hit      (eos_hit),
    .car_wr_hit   (car_wr_hit),
    .car_wdata    (wdata[CHAN_W-1:0]),
    .ignore_evt   (ignore_evt),
    .car          (car),
    .mode         (mode),
    .active       (active),
    .save_car     (save_car),
    .save_mode    (save_mode),
    .ignored_flag (ignored_flag)
  );

  always_comb begin
    status           = '0;
    status[DATA_W-1] = ignored_flag;
    status[DATA_W-2] = active;
    status[1:0]      = mode;
  end

  svc_bus_port #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_bus (
    .live     (live),
    .vec_q    (vec_q),
    .rd_sel   (rd_sel),
    .addr     (addr),
    .car      (car),
    .status   (status),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
  );

endmodule

// File: rtl/svc_ack_chk.sv
module svc_ack_chk
  import svc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        winner,
  input logic              any_fall,
  input logic              ctx_switch,
  input logic              eos_hit,
  input logic              active,
  input logic [CHAN_W-1:0] car,
  input logic [CHAN_W-1:0] save_car,
  input svc_mode_e         mode,
  input svc_mode_e         save_mode,
  input logic              ignored_flag,
  input logic              live,
  input logic              rdata_oe,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] vec_q
);

  p_one_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner));

  p_switch_enters_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_switch |=> (active && mode != MODE_NORM));

  p_no_pend_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_fall && !ctx_switch) |=> (vec_q == '0));

  p_nested_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_fall && active) |=> (ignored_flag && $stable(car) && $stable(mode)));

  p_eos_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eos_hit |=> (!active && car == $past(save_car) && mode == $past(save_mode)));

  p_car_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !eos_hit) |=> $stable(car));

  p_live_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (rdata_oe && rdata == vec_q));

endmodule

bind svc_ack_ctrl svc_ack_chk #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .winner       (winner),
  .any_fall     (any_fall),
  .ctx_switch   (ctx_switch),
  .eos_hit      (eos_hit),
  .active       (active),
  .car          (car),
  .save_car     (save_car),
  .mode         (mode),
  .save_mode    (save_mode),
  .ignored_flag (ignored_flag),
  .live         (live),
  .rdata_oe     (rdata_oe),
  .rdata        (rdata),
  .vec_q        (vec_q)
);

// File: tb/tb_svc_ack_ctrl.sv
`timescale 1ns/1ps
module tb_svc_ack_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ack_rx_n = 1'b1, ack_tx_n = 1'b1, ack_mdm_n = 1'b1;
  logic       req_rx = 1'b1, req_tx = 1'b1, req_mdm = 1'b1;
  logic [1:0] chan_rx = 2'd2, chan_tx = 2'd1;
  logic [7:0] mdm_irq = 8'hA3;
  logic [4:0] chip_id = 5'h15;
  logic [2:0] kind_rx = 3'd1, kind_tx = 3'd2, kind_mdm = 3'd3;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rdata_oe;

  int checks = 0;
  int errors = 0;

  // Expected vectors: chip ID in [7:3], kind in [2:0]
  localparam logic [7:0] V_RX  = {5'h15, 3'd1};
  localparam logic [7:0] V_TX  = {5'h15, 3'd2};
  localparam logic [7:0] V_MDM = {5'h15, 3'd3};

  always #2.5 clk = ~clk;

  svc_ack_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .ack_rx_n(ack_rx_n), .ack_tx_n(ack_tx_n), .ack_mdm_n(ack_mdm_n),
    .req_rx(req_rx), .req_tx(req_tx), .req_mdm(req_mdm),
    .chan_rx(chan_rx), .chan_tx(chan_tx), .mdm_irq(mdm_irq),
    .chip_id(chip_id), .kind_rx(kind_rx), .kind_tx(kind_tx), .kind_mdm(kind_mdm),
    .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    chk("R8 oe on read", {7'd0, rdata_oe}, 8'd1);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic expect_regs(input string tag, input logic [7:0] car_e, input logic [7:0] st_e);
    logic [7:0] d;
    reg_read(2'd0, d); chk({tag, " channel"}, d, car_e);
    reg_read(2'd1, d); chk({tag, " status"}, d, st_e);
  endtask

  // mask bit0 receive, bit1 transmit, bit2 modem
  task automatic ack_seq(input logic [2:0] mask, input logic [7:0] exp_vec, input string tag);
    @(negedge clk);
    {ack_mdm_n, ack_tx_n, ack_rx_n} = ~mask;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 no drive before sync done", {7'd0, rdata_oe}, 8'd0);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " oe"}, {7'd0, rdata_oe}, 8'd1);
    chk({tag, " vector"}, rdata, exp_vec);
    {ack_mdm_n, ack_tx_n, ack_rx_n} = 3'b111;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 oe drops after release", {7'd0, rdata_oe}, 8'd0);
  endtask

  task automatic t_reset;
    chk("R1 oe idle", {7'd0, rdata_oe}, 8'd0);
    expect_regs("R1", 8'h00, 8'h00);
  endtask

  task automatic t_idle_car_write;
    reg_write(2'd0, 8'h01);
    expect_regs("R7 idle write", 8'h01, 8'h00);
  endtask

  task automatic t_rx_service;
    ack_seq(3'b001, V_RX, "R2 rx");
    expect_regs("R3 rx", 8'h02, 8'h41);
    reg_write(2'd0, 8'h03);
    expect_regs("R7 write in service", 8'h02, 8'h41);
    ack_seq(3'b010, 8'h00, "R5 nested");
    expect_regs("R5 nested", 8'h02, 8'hC1);
    reg_write(2'd2, 8'h5A);
    expect_regs("R6 restore", 8'h01, 8'h00);
  endtask

  task automatic t_eos_idle;
    reg_write(2'd2, 8'hFF);
    expect_regs("R6 idle eos", 8'h01, 8'h00);
  endtask

  task automatic t_tx_mdm;
    ack_seq(3'b010, V_TX, "R2 tx");
    expect_regs("R3 tx", 8'h01, 8'h42);
    reg_write(2'd2, 8'h00);
    ack_seq(3'b100, V_MDM, "R2 mdm");
    expect_regs("R3 mdm", 8'h03, 8'h43);
    reg_write(2'd2, 8'h00);
    expect_regs("R6 after mdm", 8'h01, 8'h00);
  endtask

  task automatic t_no_request;
    req_rx = 1'b0;
    ack_seq(3'b001, 8'h00, "R4 no request");
    expect_regs("R4", 8'h01, 8'h00);
    req_rx = 1'b1;
  endtask

  task automatic t_simultaneous;
    ack_seq(3'b011, V_RX, "R9 priority");
    expect_regs("R9", 8'h02, 8'hC1);
    reg_write(2'd2, 8'h00);
    expect_regs("R9 cleanup", 8'h01, 8'h00);
  endtask

  task automatic t_bus_misc;
    logic [7:0] d;
    @(negedge clk);
    cs = 1'b1; rd = 1'b0;
    #1 chk("R8 cs without rd", {7'd0, rdata_oe}, 8'd0);
    cs = 1'b0;
    reg_read(2'd3, d);
    chk("R10 unused address", d, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_idle_car_write();
    t_rx_service();
    t_eos_idle();
    t_tx_mdm();
    t_no_request();
    t_simultaneous();
    t_bus_misc();
    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule